// File: doc/BRIEF.md
# Select-Strobe Settling Sequencer

This block sits at the front of a bus slave. It watches an active-low select strobe from a host, and the slave is clocked by a slow local clock that has no frequency or phase relationship to that strobe. The host's mode line, direction line and data bus are still changing around both edges of select. The block therefore never latches on a select edge. It synchronises select and the local clock into a fast system clock domain. When select falls it clears a small counter, and the counter then advances on every falling edge of the local clock. When the second fall arrives, the block captures mode, direction and data and pulses a capture strobe.

After the capture, the block picks the moment at which the shared open-drain ready line is let go. Ready is always released on a rising edge of the local clock. The operation type decides which rising edge: a short cycle waits for two falls and a long cycle waits for three. Ready then stays released until select rises. At that point it is pulled low again and the counter returns to zero. If select rises before release, the sequence is abandoned. The block only produces capture and release timing. The slave core performs the operations and supplies the byte-order flag that separates the two halves of an address write.

Top module: `strobe_settle_seq`

## Requirements
- R1: After reset, `rdy_low` is 1, and `cap_stb` and `rel_stb` are 0.
- R2: A select fall clears the fall counter. `cap_stb` pulses only after the second falling edge of `lclk` seen while select is low, never on the select edge itself.
- R3: `cap_mode`, `cap_dir` and `cap_data` hold the values present on the inputs at the second `lclk` fall, not the values present when select fell.
- R4: `cap_stb` is a single-cycle pulse and occurs at most once per select-low period.
- R5: First address-write byte (`mode_in`=1 meaning address, `dir_in`=0 meaning write, `byte_hi_in`=0 meaning first byte): ready is released on the first `lclk` rise after 2 falls.
- R6: Second address-write byte (`mode_in`=1, `dir_in`=0, `byte_hi_in`=1) and data read (`mode_in`=0, `dir_in`=1, either `byte_hi_in`): ready is released on the first `lclk` rise after 3 falls.
- R7: Data write (`mode_in`=0, `dir_in`=0) and address read (`mode_in`=1, `dir_in`=1): ready is released on the first `lclk` rise after 2 falls.
- R8: Release happens only in response to a rising edge of `lclk`. `rel_stb` pulses for one cycle in the same cycle that `rdy_low` drops to 0, and `rdy_low` stays 1 until then.
- R9: Once released, `rdy_low` stays 0 until select rises. It then returns to 1 within a few system clocks, and the next select cycle starts from a zero count.
- R10: A select rise before release abandons the sequence: no `rel_stb` is produced and `rdy_low` stays 1. A rise before the second fall also suppresses `cap_stb`.
- R11: While select stays low after release, further `lclk` edges produce no further strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Host select strobe, active low, asynchronous |
| lclk | input | 1 | Slow local clock, asynchronous |
| mode_in | input | 1 | 1 = address access, 0 = data access |
| dir_in | input | 1 | 1 = read, 0 = write |
| byte_hi_in | input | 1 | From slave core: 1 = second address byte expected |
| data_in | input | DATA_W | Host data bus |
| cap_stb | output | 1 | One-cycle pulse: captured fields valid |
| cap_mode | output | 1 | Captured mode |
| cap_dir | output | 1 | Captured direction |
| cap_data | output | DATA_W | Captured data |
| rel_stb | output | 1 | One-cycle pulse at ready release |
| rdy_low | output | 1 | 1 = pull ready line low, 0 = let it float |

## Verification
Every combination of mode, direction and byte flag goes through a full select cycle. In each cycle the inputs start at deliberately wrong values and settle only after the first local-clock fall, which separates capture at the settle count from capture at the select edge. The number of local-clock falls counted by the bench before release distinguishes the two-fall cycles from the three-fall ones. The phase of `lclk` at release shows whether the release follows a rising edge. Two abort patterns are also run: select rising before capture, and select rising between capture and release. A long select hold after release then confirms that ready stays released and that no strobe repeats.

// File: rtl/strobe_settle_pkg.sv
`timescale 1ns/1ps
package strobe_settle_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2,
        ST_OPEN  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/sss_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser, one independent chain per bit.
module sss_sync #(
    parameter int                WIDTH   = 2,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0] chain_q [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[b] <= {STAGES{RST_VAL[b]}};
            else        chain_q[b] <= {chain_q[b][STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain_q[b][STAGES-1];
    end
endmodule

// File: rtl/sss_edge.sv
`timescale 1ns/1ps
// Edge detection on already-synchronised signals.
module sss_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = prev_q & ~lvl;
endmodule

// File: rtl/sss_core.sv
`timescale 1ns/1ps
// Settle counter, capture and ready-release sequencing.
module sss_core
    import strobe_settle_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SETTLE_FALLS = 2,
    parameter int SHORT_FALLS  = 2,
    parameter int LONG_FALLS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_start,
    input  logic              sel_end,
    input  logic              lck_rise,
    input  logic              lck_fall,
    input  logic              mode_in,
    input  logic              dir_in,
    input  logic              byte_hi_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              cap_stb,
    output logic              cap_mode,
    output logic              cap_dir,
    output logic [DATA_W-1:0] cap_data,
    output logic              rel_stb,
    output logic              rdy_low
);
    localparam int CNT_W = $clog2(LONG_FALLS + 1);
    localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE_FALLS);
    localparam logic [CNT_W-1:0] SHORT_C  = CNT_W'(SHORT_FALLS);
    localparam logic [CNT_W-1:0] LONG_C   = CNT_W'(LONG_FALLS);
    localparam logic [CNT_W-1:0] PRE_CAP  = CNT_W'(SETTLE_FALLS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  need;
        logic              cap_stb;
        logic              rel_stb;
        logic              rdy_low;
        logic              mode;
        logic              dir;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    function automatic logic [CNT_W-1:0] falls_needed(input logic m, input logic d, input logic hi);
        logic addr_wr_hi, data_rd;
        addr_wr_hi = m & ~d & hi;
        data_rd    = ~m & d;
        return (addr_wr_hi | data_rd) ? LONG_C : SHORT_C;
    endfunction

    always_comb begin
        r_d         = r_q;
        r_d.cap_stb = 1'b0;
        r_d.rel_stb = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.rdy_low = 1'b1;
                r_d.cnt     = '0;
                if (sel_start) r_d.st = ST_COUNT;
            end
            ST_COUNT: begin
                if (sel_end) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                end else if (lck_fall) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == PRE_CAP) begin
                        r_d.st      = ST_HOLD;
                        r_d.cap_stb = 1'b1;
                        r_d.mode    = mode_in;
                        r_d.dir     = dir_in;
                        r_d.data    = data_in;
                        r_d.need    = falls_needed(mode_in, dir_in, byte_hi_in);
                    end
                end
            end
            ST_HOLD: begin
                if (sel_end) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                end else begin
                    if (lck_fall && r_q.cnt < LONG_C) r_d.cnt = r_q.cnt + 1'b1;
                    if (lck_rise && r_q.cnt >= r_q.need) begin
                        r_d.st      = ST_OPEN;
                        r_d.rdy_low = 1'b0;
                        r_d.rel_stb = 1'b1;
                    end
                end
            end
            ST_OPEN: begin
                if (sel_end) begin
                    r_d.st      = ST_IDLE;
                    r_d.rdy_low = 1'b1;
                    r_d.cnt     = '0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.rdy_low <= 1'b1;
            r_q.need    <= SHORT_C;
        end else begin
            r_q <= r_d;
        end
    end

    assign cap_stb  = r_q.cap_stb;
    assign cap_mode = r_q.mode;
    assign cap_dir  = r_q.dir;
    assign cap_data = r_q.data;
    assign rel_stb  = r_q.rel_stb;
    assign rdy_low  = r_q.rdy_low;

    // R4
    cap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> !cap_stb);
    // R2
    cap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> (r_q.cnt == SETTLE_C && $past(lck_fall)));
    // R8
    rel_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_stb |-> ($past(lck_rise) && !rdy_low));
    // R6
    rel_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_stb |-> r_q.cnt >= r_q.need);
    // R9
    open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OPEN && !sel_end) |=> !rdy_low);
    // R9
    end_relow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_end |=> (rdy_low && r_q.cnt == '0));
    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_stb && rel_stb));
endmodule

// File: rtl/strobe_settle_seq.sv
`timescale 1ns/1ps
module strobe_settle_seq #(
    parameter int DATA_W       = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int SETTLE_FALLS = 2,
    parameter int SHORT_FALLS  = 2,
    parameter int LONG_FALLS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              lclk,
    input  logic              mode_in,
    input  logic              dir_in,
    input  logic              byte_hi_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              cap_stb,
    output logic              cap_mode,
    output logic              cap_dir,
    output logic [DATA_W-1:0] cap_data,
    output logic              rel_stb,
    output logic              rdy_low
);
    localparam int           N_ASYNC  = 2;
    localparam logic [1:0]   ASYNC_RV = 2'b10;  // {sel_n idle high, lclk low}

    logic [N_ASYNC-1:0] async_s, rise_v, fall_v;

    sss_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES), .RST_VAL(ASYNC_RV)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in({sel_n, lclk}), .sync_out(async_s));

    sss_edge #(.WIDTH(N_ASYNC), .RST_VAL(ASYNC_RV)) edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(async_s), .rise(rise_v), .fall(fall_v));

    sss_core #(
        .DATA_W(DATA_W), .SETTLE_FALLS(SETTLE_FALLS),
        .SHORT_FALLS(SHORT_FALLS), .LONG_FALLS(LONG_FALLS)
    ) core_i (
        .clk(clk), .rst_n(rst_n),
        .sel_start(fall_v[1]), .sel_end(rise_v[1]),
        .lck_rise(rise_v[0]), .lck_fall(fall_v[0]),
        .mode_in(mode_in), .dir_in(dir_in), .byte_hi_in(byte_hi_in), .data_in(data_in),
        .cap_stb(cap_stb), .cap_mode(cap_mode), .cap_dir(cap_dir), .cap_data(cap_data),
        .rel_stb(rel_stb), .rdy_low(rdy_low));
endmodule

// File: tb/strobe_settle_seq_tb_top.sv
`timescale 1ns/1ps
module strobe_settle_seq_tb_top;
    logic       clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, lclk = 1'b0;
    logic       mode_in = 1'b0, dir_in = 1'b0, byte_hi_in = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       cap_stb, cap_mode, cap_dir, rel_stb, rdy_low;
    logic [7:0] cap_data;

    int n_chk = 0, n_fail = 0;
    int fall_cnt = 0, cap_seen = 0, rel_seen = 0, cap_falls = 0, rel_falls = 0;
    logic       rel_lhigh = 1'b0, cap_rdy = 1'b0, cap_m = 1'b0, cap_d = 1'b0;
    logic [7:0] cap_v = 8'h00;
    realtime    last_rise = 0.0, rel_dt = 0.0;

    always #10 clk = ~clk;       // 50 MHz
    always #1037 lclk = ~lclk;   // unrelated slow clock, about 482 kHz

    strobe_settle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .lclk(lclk),
        .mode_in(mode_in), .dir_in(dir_in), .byte_hi_in(byte_hi_in), .data_in(data_in),
        .cap_stb(cap_stb), .cap_mode(cap_mode), .cap_dir(cap_dir), .cap_data(cap_data),
        .rel_stb(rel_stb), .rdy_low(rdy_low));

    always @(negedge lclk) if (!sel_n) fall_cnt++;
    always @(posedge lclk) last_rise = $realtime;

    always @(negedge clk) begin
        if (cap_stb) begin
            cap_seen++; cap_falls = fall_cnt; cap_v = cap_data;
            cap_m = cap_mode; cap_d = cap_dir; cap_rdy = rdy_low;
        end
        if (rel_stb) begin
            rel_seen++; rel_falls = fall_cnt; rel_lhigh = lclk;
            rel_dt = $realtime - last_rise;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_sel(input logic m_e, input logic d_e, input logic [7:0] v_e);
        @(posedge lclk); #200;
        fall_cnt = 0; cap_seen = 0; rel_seen = 0;
        mode_in = m_e; dir_in = d_e; data_in = v_e; byte_hi_in = ~byte_hi_in;
        sel_n = 1'b0;
    endtask

    task automatic wait_rel();
        for (int i = 0; i < 3000 && rel_seen == 0; i++) @(negedge clk);
    endtask

    // {mode, dir, byte_hi, early data, settled data, falls to release}
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 8'h5A, 8'h12, 2'd2},
        {1'b1, 1'b0, 1'b1, 8'hFF, 8'h34, 2'd3},
        {1'b0, 1'b1, 1'b0, 8'h00, 8'hA5, 2'd3},
        {1'b0, 1'b1, 1'b1, 8'h3C, 8'hC3, 2'd3},
        {1'b0, 1'b0, 1'b0, 8'h81, 8'h7E, 2'd2},
        {1'b0, 1'b0, 1'b1, 8'h0F, 8'hF0, 2'd2},
        {1'b1, 1'b1, 1'b0, 8'h11, 8'hEE, 2'd2},
        {1'b1, 1'b1, 1'b1, 8'h99, 8'h66, 2'd2}
    };

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (5) @(negedge clk);
        chk(rdy_low == 1'b1, "R1 rdy_low in reset", int'(rdy_low), 1);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(rdy_low == 1'b1 && !cap_stb && !rel_stb, "R1 idle outputs",
            int'({rdy_low, cap_stb, rel_stb}), 4);

        for (int k = 0; k < NV; k++) begin
            logic m, d, h; logic [7:0] ve, vf; int need;
            {m, d, h, ve, vf} = VEC[k][20:2];
            need = int'(VEC[k][1:0]);
            start_sel(~m, ~d, ve);
            @(negedge lclk); #100;
            mode_in = m; dir_in = d; byte_hi_in = h; data_in = vf;
            wait_rel();
            chk(cap_seen == 1, "R4 one capture", cap_seen, 1);
            chk(cap_falls == 2, "R2 capture after two falls", cap_falls, 2);
            chk(cap_v == vf, "R3 settled data", int'(cap_v), int'(vf));
            chk({cap_m, cap_d} == {m, d}, "R3 settled mode/dir", int'({cap_m, cap_d}), int'({m, d}));
            chk(cap_rdy == 1'b1, "R8 ready held at capture", int'(cap_rdy), 1);
            if (need == 3) chk(rel_falls == 3, "R6 long release", rel_falls, 3);
            else if (m && !d) chk(rel_falls == 2, "R5 short release", rel_falls, 2);
            else chk(rel_falls == 2, "R7 short release", rel_falls, 2);
            chk(rel_lhigh == 1'b1 && rel_dt < 200.0, "R8 release after lclk rise",
                int'(rel_dt), 200);
            #4200;
            chk(rdy_low == 1'b0, "R9 ready stays released", int'(rdy_low), 0);
            chk(cap_seen == 1 && rel_seen == 1, "R11 no extra strobes",
                cap_seen * 10 + rel_seen, 11);
            sel_n = 1'b1;
            repeat (10) @(negedge clk);
            chk(rdy_low == 1'b1, "R9 ready low after select rise", int'(rdy_low), 1);
        end

        // R10 abort before capture
        start_sel(1'b0, 1'b1, 8'h44);
        @(negedge lclk); #100;
        sel_n = 1'b1;
        #6300;
        chk(cap_seen == 0, "R10 no capture after early abort", cap_seen, 0);
        chk(rel_seen == 0 && rdy_low == 1'b1, "R10 no release after early abort",
            rel_seen, 0);

        // R10 abort between capture and release (data read needs 3 falls)
        start_sel(1'b0, 1'b1, 8'h55);
        @(negedge lclk); #100;
        @(negedge lclk); #300;
        chk(cap_seen == 1, "R10 capture before late abort", cap_seen, 1);
        sel_n = 1'b1;
        #6300;
        chk(rel_seen == 0 && rdy_low == 1'b1, "R10 no release after late abort",
            rel_seen, 0);

        // R9 counter restarts from zero after aborts
        start_sel(1'b1, 1'b0, 8'h21);
        @(negedge lclk); #100;
        mode_in = 1'b1; dir_in = 1'b0; byte_hi_in = 1'b0; data_in = 8'h21;
        wait_rel();
        chk(cap_falls == 2 && rel_falls == 2, "R9 fresh count after abort",
            cap_falls * 10 + rel_falls, 22);
        sel_n = 1'b1;
        repeat (10) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule